// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 2K x 8 Static RAM

This block sits between a clocked system bus and an external asynchronous static RAM that holds 2048 bytes. The system side hands it one word at a time: a request with an 11-bit address, a direction bit and, for writes, one byte of data. The block then plays out the chip select, output enable, write enable, address and data-bus sequence that the memory needs. It answers with a one-cycle ready pulse, which carries the read byte on reads.

Every interval of the pin sequence is a parameter counted in clock cycles. These intervals are the read cycle, the address, select and output-enable access times, address setup, write pulse, data setup, write-to-high-impedance, data hold, write recovery and bus turnaround. Between operations the memory is kept deselected, so it stays in its low-power standby state. A build option chooses whether output enable stays low through writes. With that option set, the write pulse is lengthened so the memory has released the bus before the controller drives it.

Top module: `asram_ctrl`

## Requirements
- R1: Throughout reset and in every cycle the block is idle, sram_cs_n, sram_we_n and sram_oe_n are 1 and sram_dq_oe is 0.
- R2: An accepted read holds sram_cs_n and sram_oe_n at 0 with sram_we_n at 1 for max(T_RC, T_AA, T_ACS, T_OE, 1) cycles. It captures sram_din at the clock edge that ends this window and then raises rsp_ready for exactly one cycle with that byte on rsp_rdata.
- R3: An accepted write lowers sram_cs_n and holds sram_we_n at 1 for T_AS cycles. It then holds sram_cs_n and sram_we_n both at 0, and sram_we_n is never 0 while sram_cs_n is 1. The stored byte is the one presented with the request and can be read back.
- R4: With OE_LOW_WR = 0, sram_oe_n stays 1 during writes and the write pulse lasts max(T_WP, max(T_DS,1)) cycles. With OE_LOW_WR = 1, sram_oe_n stays 0 through address setup and the whole pulse, and the pulse lasts max(T_WP, T_WHZ + max(T_DS,1)) cycles.
- R5: sram_addr changes only at the edge where a request is accepted. It never changes while sram_cs_n and sram_we_n are both 0.
- R6: sram_dq_oe is 1 only in the last (pulse - start) cycles of the write pulse, where start is T_WHZ when OE_LOW_WR = 1 and 0 otherwise, and for max(T_DH,1) cycles after sram_we_n rises. It is never 1 while the memory may drive (sram_cs_n = 0, sram_oe_n = 0, sram_we_n = 1).
- R7: After sram_we_n rises, rsp_ready for the write follows max(T_DH, 1, T_WR) cycles later, and the address is held until then.
- R8: After a read's ready pulse, the block returns to idle T_TA cycles later.
- R9: Requests are accepted only while idle. A request presented while busy is dropped with no write and no ready pulse, and every accepted request gets exactly one ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present (taken only while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Byte to write |
| idle | output | 1 | Controller can take a request this cycle |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_ready |
| sram_addr | output | 11 | Memory address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dout | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Tristate enable for sram_dout |
| sram_din | input | 8 | Data from the memory |

## Verification
Two events can share a cycle. A write's completion pulse coincides with the return to idle, so a new request can arrive in the same cycle as that ready pulse. A request can also arrive while a sequence is still running. The driver presents each request at the first cycle it sees idle, which after a write is the ready cycle itself. Right after one accepted write, it also injects a stray write while the controller is busy. The scoreboard judges both cases: the back-to-back request must complete with the correct byte, and a read of the stray request's address must return the old contents, with no ready pulse that has no queued request behind it.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WTAIL
  } st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // read window: last of the access times, never shorter than the cycle time
  function automatic int unsigned rd_cycles(input int unsigned t_aa, input int unsigned t_acs,
                                            input int unsigned t_oe, input int unsigned t_rc);
    return max2(max2(max2(t_aa, t_acs), max2(t_oe, t_rc)), 1);
  endfunction

  // cycle within the pulse at which write data may be driven
  function automatic int unsigned drive_start(input int unsigned t_whz, input bit oe_low);
    return oe_low ? t_whz : 0;
  endfunction

  // write pulse, stretched when output enable stays asserted
  function automatic int unsigned wp_cycles(input int unsigned t_wp, input int unsigned t_ds,
                                            input int unsigned t_whz, input bit oe_low);
    return max2(t_wp, drive_start(t_whz, oe_low) + max2(t_ds, 1));
  endfunction

  function automatic int unsigned hold_cycles(input int unsigned t_dh);
    return max2(t_dh, 1);
  endfunction

  function automatic int unsigned tail_cycles(input int unsigned t_dh, input int unsigned t_wr);
    return max2(hold_cycles(t_dh), t_wr);
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          done
);

  assign done = (cnt_q == '0);

  always_comb begin
    if (load)      cnt_nxt = load_val;
    else if (done) cnt_nxt = cnt_q;
    else           cnt_nxt = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int          CW        = 4,
  parameter int unsigned RD_LEN    = 4,
  parameter int unsigned WSU_LEN   = 1,
  parameter int unsigned WP_LEN    = 3,
  parameter int unsigned DRV_START = 0,
  parameter int unsigned HOLD_LEN  = 1,
  parameter int unsigned TAIL_LEN  = 1,
  parameter int unsigned TURN_LEN  = 1,
  parameter bit          OE_LOW    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output st_e  state_q,
  output logic acc_fire,
  output logic rd_done,
  output logic wr_done,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam logic [CW-1:0] RD_M1   = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] WSU_M1  = CW'((WSU_LEN > 0) ? WSU_LEN - 1 : 0);
  localparam logic [CW-1:0] WP_M1   = CW'(WP_LEN - 1);
  localparam logic [CW-1:0] TAIL_M1 = CW'(TAIL_LEN - 1);
  localparam logic [CW-1:0] TURN_M1 = CW'((TURN_LEN > 0) ? TURN_LEN - 1 : 0);
  localparam logic [CW-1:0] DRV_LIM = CW'(WP_LEN - 1 - DRV_START);
  localparam logic [CW:0]   HOLD_GE = (CW+1)'(TAIL_LEN - HOLD_LEN);

  st_e           nxt;
  logic          load;
  logic [CW-1:0] lval;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          done;
  logic          oe_nxt;
  logic          dq_nxt;

  asram_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(lval),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .done    (done)
  );

  assign acc_fire = (state_q == ST_IDLE) && req_valid;
  assign rd_done  = (state_q == ST_READ) && done;
  assign wr_done  = (state_q == ST_WTAIL) && done;

  always_comb begin
    nxt  = state_q;
    load = 1'b0;
    lval = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        load = 1'b1;
        if (!req_write) begin
          nxt  = ST_READ;
          lval = RD_M1;
        end else if (WSU_LEN > 0) begin
          nxt  = ST_WSETUP;
          lval = WSU_M1;
        end else begin
          nxt  = ST_WPULSE;
          lval = WP_M1;
        end
      end
      ST_READ: if (done) begin
        if (TURN_LEN > 0) begin
          nxt  = ST_TURN;
          load = 1'b1;
          lval = TURN_M1;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_TURN:   if (done) nxt = ST_IDLE;
      ST_WSETUP: if (done) begin
        nxt  = ST_WPULSE;
        load = 1'b1;
        lval = WP_M1;
      end
      ST_WPULSE: if (done) begin
        nxt  = ST_WTAIL;
        load = 1'b1;
        lval = TAIL_M1;
      end
      ST_WTAIL:  if (done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe_nxt = !((nxt == ST_READ) || (nxt == ST_WSETUP) || (nxt == ST_WPULSE));
    end else begin : g_oe_high
      assign oe_nxt = !(nxt == ST_READ);
    end
  endgenerate

  assign dq_nxt = ((nxt == ST_WPULSE) && (cnt_nxt <= DRV_LIM)) ||
                  ((nxt == ST_WTAIL) && (({1'b0, cnt_nxt} + 1'b1) > HOLD_GE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= nxt;
      cs_n    <= !((nxt == ST_READ) || (nxt == ST_WSETUP) || (nxt == ST_WPULSE));
      we_n    <= !(nxt == ST_WPULSE);
      oe_n    <= oe_nxt;
      dq_oe   <= dq_nxt;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          DATA_W    = 8,
  parameter int unsigned T_RC      = 4,
  parameter int unsigned T_AA      = 3,
  parameter int unsigned T_ACS     = 2,
  parameter int unsigned T_OE      = 2,
  parameter int unsigned T_AS      = 1,
  parameter int unsigned T_WP      = 3,
  parameter int unsigned T_DS      = 2,
  parameter int unsigned T_WHZ     = 2,
  parameter int unsigned T_DH      = 2,
  parameter int unsigned T_WR      = 1,
  parameter int unsigned T_TA      = 2,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              idle,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dout,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_din
);

  localparam int unsigned RD_LEN   = rd_cycles(T_AA, T_ACS, T_OE, T_RC);
  localparam int unsigned WP_LEN   = wp_cycles(T_WP, T_DS, T_WHZ, OE_LOW_WR);
  localparam int unsigned DRV_ST   = drive_start(T_WHZ, OE_LOW_WR);
  localparam int unsigned HOLD_LEN = hold_cycles(T_DH);
  localparam int unsigned TAIL_LEN = tail_cycles(T_DH, T_WR);
  localparam int unsigned MAX_LEN  = max2(max2(max2(RD_LEN, WP_LEN), max2(TAIL_LEN, T_AS)), T_TA);
  localparam int          CW       = $clog2(MAX_LEN + 1);

  st_e  st;
  logic acc_fire;
  logic rd_done;
  logic wr_done;

  asram_seq #(
    .CW       (CW),
    .RD_LEN   (RD_LEN),
    .WSU_LEN  (T_AS),
    .WP_LEN   (WP_LEN),
    .DRV_START(DRV_ST),
    .HOLD_LEN (HOLD_LEN),
    .TAIL_LEN (TAIL_LEN),
    .TURN_LEN (T_TA),
    .OE_LOW   (OE_LOW_WR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .state_q  (st),
    .acc_fire (acc_fire),
    .rd_done  (rd_done),
    .wr_done  (wr_done),
    .cs_n     (sram_cs_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe)
  );

  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      sram_dout <= '0;
      rsp_rdata <= '0;
      rsp_ready <= 1'b0;
    end else begin
      if (acc_fire) begin
        sram_addr <= req_addr;
        if (req_write) sram_dout <= req_wdata;
      end
      if (rd_done) rsp_rdata <= sram_din;
      rsp_ready <= rd_done || wr_done;
    end
  end

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter bit OE_LOW = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              acc_fire,
  input logic              rd_done,
  input logic              wr_done,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe
);

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_read_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (!sram_cs_n && !sram_oe_n && sram_we_n));

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  p_we_under_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n);

  generate
    if (OE_LOW) begin : g_oe_low
      p_oe_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_oe_n);
    end else begin : g_oe_high
      p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);
    end
  endgenerate

  p_addr_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !sram_we_n) |=> $stable(sram_addr));

  p_addr_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> $stable(sram_addr));

  p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !sram_oe_n && sram_we_n) |-> !sram_dq_oe);

  p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  p_write_ends_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (rsp_ready && idle));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !idle);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .OE_LOW(OE_LOW_WR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle      (idle),
  .acc_fire  (acc_fire),
  .rd_done   (rd_done),
  .wr_done   (wr_done),
  .rsp_ready (rsp_ready),
  .sram_addr (sram_addr),
  .sram_cs_n (sram_cs_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps

module asram_tb_mem #(
  parameter int ACC = 3
) (
  input  logic        clk,
  input  logic [10:0] addr,
  input  logic        cs_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [7:0]  wd,
  input  logic        wd_en,
  output logic [7:0]  rd,
  output int          n_addr_bad,
  output int          n_clash
);
  logic [7:0]  arr [0:2047];
  logic        wr_act;
  logic [10:0] prev_addr;
  int          age;

  initial begin
    for (int i = 0; i < 2048; i++) arr[i] = 8'h00;
    age = 0; n_addr_bad = 0; n_clash = 0; prev_addr = '0;
  end

  assign wr_act = !cs_n && !we_n;
  assign rd = (age >= ACC) ? arr[addr] : 8'hEE;

  always @(negedge wr_act) if (wd_en === 1'b1) arr[addr] = wd;

  always @(negedge clk) begin
    if (cs_n === 1'b0 && oe_n === 1'b0 && we_n === 1'b1) age <= age + 1;
    else age <= 0;
    if (wr_act === 1'b1 && addr !== prev_addr) n_addr_bad <= n_addr_bad + 1;
    if (cs_n === 1'b0 && oe_n === 1'b0 && we_n === 1'b1 && wd_en === 1'b1) n_clash <= n_clash + 1;
    prev_addr <= addr;
  end
endmodule

module asram_ctrl_tb_top;
  localparam int RD_W   = 4;   // max(4,3,2,2)
  localparam int ACC_W  = 3;   // max(3,2,2)
  localparam int WP0    = 3;   // max(3,2), output enable high
  localparam int WP1    = 4;   // max(3,2+2), output enable low
  localparam int DRV0   = 5;   // 3 pulse cycles + 2 hold
  localparam int DRV1   = 4;   // (4-2) pulse cycles + 2 hold
  localparam int TAIL   = 2;   // max(2,1,1)
  localparam int TURN   = 2;

  typedef struct { bit is_rd; logic [7:0] data; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;

  logic idle0, rdy0, cs0, oe0, we0, dq0;
  logic [7:0] rdat0, dout0, din0;
  logic [10:0] addr0;
  logic idle1, rdy1, cs1, oe1, we1, dq1;
  logic [7:0] rdat1, dout1, din1;
  logic [10:0] addr1;
  int bad_a0, clash0, bad_a1, clash1;

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;
  item_t q0[$], q1[$];
  logic [7:0] shadow [0:2047];

  always #10 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle0), .rsp_ready(rdy0),
    .rsp_rdata(rdat0), .sram_addr(addr0), .sram_cs_n(cs0), .sram_oe_n(oe0),
    .sram_we_n(we0), .sram_dout(dout0), .sram_dq_oe(dq0), .sram_din(din0));

  asram_ctrl #(.OE_LOW_WR(1'b1)) dut_oe_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle1), .rsp_ready(rdy1),
    .rsp_rdata(rdat1), .sram_addr(addr1), .sram_cs_n(cs1), .sram_oe_n(oe1),
    .sram_we_n(we1), .sram_dout(dout1), .sram_dq_oe(dq1), .sram_din(din1));

  asram_tb_mem #(.ACC(ACC_W)) mem0 (.clk(clk), .addr(addr0), .cs_n(cs0), .oe_n(oe0),
    .we_n(we0), .wd(dout0), .wd_en(dq0), .rd(din0), .n_addr_bad(bad_a0), .n_clash(clash0));
  asram_tb_mem #(.ACC(ACC_W)) mem1 (.clk(clk), .addr(addr1), .cs_n(cs1), .oe_n(oe1),
    .we_n(we1), .wd(dout1), .wd_en(dq1), .rd(din1), .n_addr_bad(bad_a1), .n_clash(clash1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [10:0] a, input logic [7:0] d);
    item_t it;
    do @(negedge clk); while (!(idle0 && idle1));
    it.is_rd = !wr;
    if (wr) begin shadow[a] = d; it.data = d; end
    else it.data = shadow[a];
    q0.push_back(it);
    q1.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard and timing monitors, sampled away from the active edge
  int we_run0 = 0, dq_run0 = 0, oe_run0 = 0, wr_since0 = 0, rd_since0 = 0;
  bit wr_arm0 = 0, rd_arm0 = 0;
  int we_run1 = 0, dq_run1 = 0;

  always @(negedge clk) begin : mon0
    item_t it;
    if (rst_n && !fin) begin
      if (idle0) chk(cs0 && we0 && oe0 && !dq0, "R1 standby dut_i", {cs0, we0, oe0, dq0}, 4'b1110);
      if (rdy0) begin
        if (q0.size() == 0) chk(1'b0, "R9 spurious ready dut_i", 1, 0);
        else begin
          it = q0.pop_front();
          if (it.is_rd) begin
            chk(rdat0 == it.data, "R2 read data dut_i", rdat0, it.data);
            rd_arm0 = 1; rd_since0 = 1;
          end
        end
      end else if (rd_arm0) begin
        if (idle0) begin chk(rd_since0 == TURN, "R8 turnaround", rd_since0, TURN); rd_arm0 = 0; end
        else rd_since0++;
      end
      if (wr_arm0) begin
        wr_since0++;
        if (rdy0) begin chk(wr_since0 == TAIL, "R7 write recovery", wr_since0, TAIL); wr_arm0 = 0; end
      end
      if (!we0) we_run0++;
      else if (we_run0 != 0) begin
        chk(we_run0 == WP0, "R4 pulse dut_i", we_run0, WP0);
        chk(dq0 == 1'b1, "R6 hold after release", dq0, 1);
        we_run0 = 0; wr_arm0 = 1; wr_since0 = 0;
      end
      if (dq0) dq_run0++;
      else if (dq_run0 != 0) begin chk(dq_run0 == DRV0, "R6 drive window dut_i", dq_run0, DRV0); dq_run0 = 0; end
      if (!oe0) oe_run0++;
      else if (oe_run0 != 0) begin chk(oe_run0 == RD_W, "R2 read window", oe_run0, RD_W); oe_run0 = 0; end
    end
  end

  always @(negedge clk) begin : mon1
    item_t it;
    if (rst_n && !fin) begin
      if (idle1) chk(cs1 && we1 && oe1 && !dq1, "R1 standby dut_oe_i", {cs1, we1, oe1, dq1}, 4'b1110);
      if (rdy1) begin
        if (q1.size() == 0) chk(1'b0, "R9 spurious ready dut_oe_i", 1, 0);
        else begin
          it = q1.pop_front();
          if (it.is_rd) chk(rdat1 == it.data, "R2 read data dut_oe_i", rdat1, it.data);
        end
      end
      if (!we1) begin
        we_run1++;
        if (oe1) chk(1'b0, "R4 oe kept low in write", oe1, 0);
      end else if (we_run1 != 0) begin
        chk(we_run1 == WP1, "R4 stretched pulse dut_oe_i", we_run1, WP1);
        we_run1 = 0;
      end
      if (dq1) dq_run1++;
      else if (dq_run1 != 0) begin chk(dq_run1 == DRV1, "R6 drive window dut_oe_i", dq_run1, DRV1); dq_run1 = 0; end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 2048; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: pins during reset
    chk(cs0 && we0 && oe0 && !dq0 && !rdy0, "R1 reset pins dut_i", {cs0, we0, oe0, dq0}, 4'b1110);
    chk(cs1 && we1 && oe1 && !dq1 && !rdy1, "R1 reset pins dut_oe_i", {cs1, we1, oe1, dq1}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle0 && idle1, "R1 idle after reset", {idle0, idle1}, 2'b11);

    // R3: writes with corner addresses and data, then readback
    issue(1, 11'h000, 8'h5A);
    issue(1, 11'h7FF, 8'hA5);
    issue(1, 11'h123, 8'hFF);
    issue(1, 11'h456, 8'h00);
    issue(0, 11'h000, 8'h00);
    issue(0, 11'h7FF, 8'h00);
    issue(0, 11'h123, 8'h00);
    issue(0, 11'h456, 8'h00);
    issue(0, 11'h200, 8'h00);   // never written

    // R9: stray request while busy must be dropped
    issue(1, 11'h010, 8'h3C);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h321; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    issue(0, 11'h321, 8'h00);   // R9: expect old contents
    issue(0, 11'h010, 8'h00);

    // write followed directly by read of the same word, then a pattern sweep
    issue(1, 11'h055, 8'hC3);
    issue(0, 11'h055, 8'h00);
    for (int i = 0; i < 16; i++) issue(1, 11'((i * 129) % 2048), 8'((i * 37) ^ 8'h3C));
    for (int i = 15; i >= 0; i--) issue(0, 11'((i * 129) % 2048), 8'h00);

    do @(negedge clk); while (!(idle0 && idle1) || q0.size() != 0 || q1.size() != 0);
    repeat (4) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, "R9 one ready per request", q0.size() + q1.size(), 0);
    chk(bad_a0 == 0 && bad_a1 == 0, "R5 address stable in write", bad_a0 + bad_a1, 0);
    chk(clash0 == 0 && clash1 == 0, "R6 no bus clash", clash0 + clash1, 0);
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule